// File: doc/BRIEF.md
# Asynchronous Interrupt Pending Controller

This block sits beside a processor's exception entry logic. It records which asynchronous interrupt sources are waiting and chooses which one to deliver next. There are three sources. The first is a level-sensitive external interrupt line. The second is a one-shot decrementer underflow pulse. The third is an imprecise floating-point enabled exception, which is raised when either of the two FP exception mode bits is set together with the FP enabled-exception summary bit.

Enables come from the machine state: an external-enable bit, plus a strobe that marks any write to the machine state or FP status. Delivery is evaluated only when one of these happens:
- a source becomes pending while it is enabled;
- the strobe finds a deliverable condition;
- an earlier delivery is acknowledged.

On delivery the block raises a request that carries a vector offset and the status bits that entry logic ORs into its saved status. The request is held until acknowledged, and only one request is outstanding at a time.

Top module: `irq_pend_ctrl`

## Requirements
- R1: During reset and after it, no request is raised and both pending flags are clear. A state-update strobe with external-enable set and no new source event raises nothing.
- R2: While `req_valid` is high and `req_ack` is low, the request stays high and `req_vector` and `req_status` do not change.
- R3: An FP condition (`fe_mode != 0` and `fex_sum`) outranks all other sources and ignores `ext_en`. It is delivered with vector 0x700 and status bits 20 and 15 set (0x0010_8000 with the default widths). External and decrementer deliveries carry status 0.
- R4: A rising `ext_line` while `ext_en` is high raises a request with vector 0x500.
- R5: With `ext_en` low, a pending external interrupt is not delivered. A later strobe with `ext_en` high delivers it.
- R6: A decrementer underflow sets a pending flag. That flag is delivered with vector 0x900 only while `ext_en` is high and no external interrupt is pending.
- R7: Acknowledging a decrementer delivery clears its flag, unless a new underflow arrives in the same cycle. Acknowledging an external delivery leaves its flag set, so the same interrupt is delivered again while the line stays high.
- R8: The external pending flag follows `ext_line`. Dropping the line clears it even if the interrupt was never delivered.
- R9: When the external and decrementer sources become pending in the same cycle, the external one is delivered first. The decrementer is delivered after that acknowledge if the line has dropped.
- R10: An acknowledge drops the request on the next edge. Events that arrive while a request is outstanding are not lost: priority is re-evaluated in the cycle after the acknowledge.
- R11: A change of `fex_sum` or `fe_mode` without a state-update strobe raises no request.
- R12: The request rises on the second clock edge after the cycle in which the triggering input is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_line | input | 1 | External interrupt level |
| dec_underflow | input | 1 | One-cycle decrementer underflow pulse |
| ext_en | input | 1 | External-enable bit of the machine state |
| fe_mode | input | 2 | FP exception mode bits |
| fex_sum | input | 1 | FP enabled-exception summary bit |
| state_upd | input | 1 | Strobe: machine state or FP status was written |
| req_ack | input | 1 | Exception entry accepted the request |
| req_valid | output | 1 | Delivery request |
| req_vector | output | VEC_W | Vector offset of the delivery |
| req_status | output | STAT_W | Bits to OR into the saved status |

## Verification
On every cycle, the assertions check four things:
- the request is held stable until it is acknowledged, and falls after the acknowledge;
- the external flag tracks the line;
- the decrementer flag sets on underflow and clears on acknowledge;
- every request carries a legal vector paired with its status pattern.

Only the bench scenarios can show the rest, because each needs a chosen history of inputs:
- priority order between sources;
- enable gating and the strobe-triggered delivery of an earlier-masked source;
- loss of an undelivered external interrupt when its line drops;
- the FP condition being ignored without a strobe;
- re-delivery after an acknowledge.

The bench compares every cycle against a behavioural model and also makes targeted checks.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_FPX  = 2'd1,
      SRC_EXT  = 2'd2,
      SRC_DEC  = 2'd3
   } irq_src_e;

endpackage

// File: rtl/irq_pend_flags.sv
module irq_pend_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_line,
   input  logic dec_underflow,
   input  logic ext_en,
   input  logic fpx_cond,
   input  logic state_upd,
   input  logic clr_dec,
   input  logic ack_evt,
   output logic ext_pend,
   output logic dec_pend,
   output logic trig
);

   logic ext_rise_en;
   logic dec_new_en;
   logic upd_hit;

   // Each of the following events schedules an evaluation of the pending sources.
   assign ext_rise_en = ext_line & ~ext_pend & ext_en;
   assign dec_new_en  = dec_underflow & ext_en;
   assign upd_hit     = state_upd & (fpx_cond | (ext_en & (ext_pend | dec_pend)));
   assign trig        = ext_rise_en | dec_new_en | upd_hit | ack_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_pend <= 1'b0;
         dec_pend <= 1'b0;
      end else begin
         ext_pend <= ext_line;
         if (dec_underflow)
            dec_pend <= 1'b1;
         else if (clr_dec)
            dec_pend <= 1'b0;
      end
   end

   AST_EXT_SET:   assert property (@(posedge clk) disable iff (!rst_n) ext_line |=> ext_pend);                 // R8
   AST_EXT_DROP:  assert property (@(posedge clk) disable iff (!rst_n) !ext_line |=> !ext_pend);               // R8
   AST_DEC_SET:   assert property (@(posedge clk) disable iff (!rst_n) dec_underflow |=> dec_pend);            // R6
   AST_DEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_dec && !dec_underflow |=> !dec_pend); // R7

endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
   import irq_pend_pkg::*;
#(
   parameter int unsigned VEC_W   = 16,
   parameter int unsigned STAT_W  = 32,
   parameter int unsigned FPE_BIT = 20,
   parameter int unsigned NXT_BIT = 15,
   parameter logic [VEC_W-1:0] V_FPX = 16'h0700,
   parameter logic [VEC_W-1:0] V_EXT = 16'h0500,
   parameter logic [VEC_W-1:0] V_DEC = 16'h0900
) (
   input  logic              fpx_cond,
   input  logic              ext_en,
   input  logic              ext_pend,
   input  logic              dec_pend,
   output logic              hit,
   output irq_src_e          src,
   output logic [VEC_W-1:0]  vec,
   output logic [STAT_W-1:0] stat
);

   logic [STAT_W-1:0] fpx_mask;

   // Build the FP status pattern: only the enabled-exception bit and the
   // subsequent-instruction bit are set.
   for (genvar i = 0; i < STAT_W; i++) begin : g_mask
      assign fpx_mask[i] = (i == FPE_BIT) || (i == NXT_BIT);
   end

   always_comb begin
      src  = SRC_NONE;
      vec  = '0;
      stat = '0;
      if (fpx_cond) begin
         src  = SRC_FPX;
         vec  = V_FPX;
         stat = fpx_mask;
      end else if (ext_en && ext_pend) begin
         src = SRC_EXT;
         vec = V_EXT;
      end else if (ext_en && dec_pend) begin
         src = SRC_DEC;
         vec = V_DEC;
      end
   end

   assign hit = (src != SRC_NONE);

endmodule

// File: rtl/irq_pend_req.sv
module irq_pend_req
   import irq_pend_pkg::*;
#(
   parameter int unsigned VEC_W  = 16,
   parameter int unsigned STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic              hit,
   input  irq_src_e          src,
   input  logic [VEC_W-1:0]  vec,
   input  logic [STAT_W-1:0] stat,
   input  logic              req_ack,
   output logic              req_valid,
   output logic [VEC_W-1:0]  req_vector,
   output logic [STAT_W-1:0] req_status,
   output logic              clr_dec,
   output logic              ack_evt
);

   logic     armed;
   irq_src_e held_src;
   logic     idle_eval;

   assign ack_evt   = req_valid & req_ack;
   assign clr_dec   = ack_evt & (held_src == SRC_DEC);
   assign idle_eval = ~req_valid & armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         req_valid  <= 1'b0;
         req_vector <= '0;
         req_status <= '0;
         held_src   <= SRC_NONE;
      end else begin
         // While a request is outstanding, a pending evaluation stays pending.
         armed <= (armed & req_valid) | trig;
         if (ack_evt) begin
            req_valid <= 1'b0;
         end else if (idle_eval && hit) begin
            req_valid  <= 1'b1;
            req_vector <= vec;
            req_status <= stat;
            held_src   <= src;
         end
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ack |=> req_valid && $stable(req_vector) && $stable(req_status)); // R2
   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack |=> !req_valid);                                              // R10

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
   import irq_pend_pkg::*;
#(
   parameter int unsigned VEC_W   = 16,
   parameter int unsigned STAT_W  = 32,
   parameter int unsigned FPE_BIT = 20,
   parameter int unsigned NXT_BIT = 15,
   parameter int unsigned VEC_FPX = 'h700,
   parameter int unsigned VEC_EXT = 'h500,
   parameter int unsigned VEC_DEC = 'h900
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_line,
   input  logic              dec_underflow,
   input  logic              ext_en,
   input  logic [1:0]        fe_mode,
   input  logic              fex_sum,
   input  logic              state_upd,
   input  logic              req_ack,
   output logic              req_valid,
   output logic [VEC_W-1:0]  req_vector,
   output logic [STAT_W-1:0] req_status
);

   localparam logic [VEC_W-1:0]  V_FPX    = VEC_W'(VEC_FPX);
   localparam logic [VEC_W-1:0]  V_EXT    = VEC_W'(VEC_EXT);
   localparam logic [VEC_W-1:0]  V_DEC    = VEC_W'(VEC_DEC);
   localparam logic [STAT_W-1:0] FPX_STAT = (STAT_W'(1) << FPE_BIT) | (STAT_W'(1) << NXT_BIT);

   if (VEC_W < 12 || VEC_W > 64) begin : g_bad_vec_w
      $error("irq_pend_ctrl: VEC_W out of range");
   end
   if (FPE_BIT >= STAT_W || NXT_BIT >= STAT_W || FPE_BIT == NXT_BIT) begin : g_bad_stat
      $error("irq_pend_ctrl: status bit positions invalid");
   end
   if (VEC_FPX == VEC_EXT || VEC_FPX == VEC_DEC || VEC_EXT == VEC_DEC) begin : g_bad_vec
      $error("irq_pend_ctrl: vector offsets must differ");
   end

   logic              fpx_cond;
   logic              ext_pend;
   logic              dec_pend;
   logic              trig;
   logic              clr_dec;
   logic              ack_evt;
   logic              hit;
   irq_src_e          src;
   logic [VEC_W-1:0]  vec;
   logic [STAT_W-1:0] stat;

   assign fpx_cond = (|fe_mode) & fex_sum;

   irq_pend_flags u_flags (
      .clk           (clk),
      .rst_n         (rst_n),
      .ext_line      (ext_line),
      .dec_underflow (dec_underflow),
      .ext_en        (ext_en),
      .fpx_cond      (fpx_cond),
      .state_upd     (state_upd),
      .clr_dec       (clr_dec),
      .ack_evt       (ack_evt),
      .ext_pend      (ext_pend),
      .dec_pend      (dec_pend),
      .trig          (trig)
   );

   irq_pend_arb #(
      .VEC_W   (VEC_W),
      .STAT_W  (STAT_W),
      .FPE_BIT (FPE_BIT),
      .NXT_BIT (NXT_BIT),
      .V_FPX   (V_FPX),
      .V_EXT   (V_EXT),
      .V_DEC   (V_DEC)
   ) u_arb (
      .fpx_cond (fpx_cond),
      .ext_en   (ext_en),
      .ext_pend (ext_pend),
      .dec_pend (dec_pend),
      .hit      (hit),
      .src      (src),
      .vec      (vec),
      .stat     (stat)
   );

   irq_pend_req #(
      .VEC_W  (VEC_W),
      .STAT_W (STAT_W)
   ) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig),
      .hit        (hit),
      .src        (src),
      .vec        (vec),
      .stat       (stat),
      .req_ack    (req_ack),
      .req_valid  (req_valid),
      .req_vector (req_vector),
      .req_status (req_status),
      .clr_dec    (clr_dec),
      .ack_evt    (ack_evt)
   );

   AST_VEC_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_vector == V_FPX && req_status == FPX_STAT)
                 || ((req_vector == V_EXT || req_vector == V_DEC) && req_status == '0)); // R3

endmodule

// File: tb/irq_pend_ctrl_test.sv
module irq_pend_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_line = 1'b0;
   logic        dec_underflow = 1'b0;
   logic        ext_en = 1'b0;
   logic [1:0]  fe_mode = 2'b00;
   logic        fex_sum = 1'b0;
   logic        state_upd = 1'b0;
   logic        req_ack = 1'b0;
   logic        req_valid;
   logic [15:0] req_vector;
   logic [31:0] req_status;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string cur_req = "R1";

   localparam logic [31:0] FPX_ST = 32'h0010_8000;

   irq_pend_ctrl uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ext_line      (ext_line),
      .dec_underflow (dec_underflow),
      .ext_en        (ext_en),
      .fe_mode       (fe_mode),
      .fex_sum       (fex_sum),
      .state_upd     (state_upd),
      .req_ack       (req_ack),
      .req_valid     (req_valid),
      .req_vector    (req_vector),
      .req_status    (req_status)
   );

   always #2.5 clk = ~clk;

   // Behavioural model of the requirements.
   bit          m_ext, m_dec, m_sched, m_valid;
   int          m_vec;
   logic [31:0] m_stat;

   always @(posedge clk) begin
      bit fp, ev, nd;
      if (!rst_n) begin
         m_ext = 0; m_dec = 0; m_sched = 0; m_valid = 0; m_vec = 0; m_stat = 0;
      end else begin
         fp = (fe_mode != 2'b00) && fex_sum;
         ev = (ext_line && !m_ext && ext_en) || (dec_underflow && ext_en)
            || (state_upd && (fp || (ext_en && (m_ext || m_dec))))
            || (m_valid && req_ack);
         nd = m_dec;
         if (m_valid && req_ack && m_vec == 'h900) nd = 0;
         if (dec_underflow) nd = 1;
         if (m_valid) begin
            if (req_ack) m_valid = 0;
            m_sched = m_sched || ev;
         end else begin
            if (m_sched) begin
               if (fp) begin m_valid = 1; m_vec = 'h700; m_stat = FPX_ST; end
               else if (ext_en && m_ext) begin m_valid = 1; m_vec = 'h500; m_stat = 0; end
               else if (ext_en && m_dec) begin m_valid = 1; m_vec = 'h900; m_stat = 0; end
            end
            m_sched = ev;
         end
         m_ext = ext_line;
         m_dec = nd;
      end
   end

   always @(negedge clk) begin
      cycles++;
      checks++;
      if (req_valid !== m_valid
          || (m_valid && (req_vector !== 16'(m_vec) || req_status !== m_stat))) begin
         errors++;
         $display("FAIL %s model compare: got v=%0b vec=%h st=%h exp v=%0b vec=%h st=%h",
                  cur_req, req_valid, req_vector, req_status, m_valid, 16'(m_vec), m_stat);
      end
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog expired: got running exp finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_req(input string tag, input bit v, input logic [15:0] vec,
                             input logic [31:0] st);
      checks++;
      if (req_valid !== v || (v && (req_vector !== vec || req_status !== st))) begin
         errors++;
         $display("FAIL %s: got v=%0b vec=%h st=%h exp v=%0b vec=%h st=%h",
                  tag, req_valid, req_vector, req_status, v, vec, st);
      end
   endtask

   task automatic do_ack();
      req_ack = 1'b1;
      cyc(1);
      req_ack = 1'b0;
   endtask

   task automatic strobe();
      state_upd = 1'b1;
      cyc(1);
      state_upd = 1'b0;
   endtask

   initial begin
      cyc(3);
      expect_req("R1 in reset", 0, 0, 0);
      rst_n = 1'b1;
      ext_en = 1'b1;
      strobe();
      cyc(3);
      expect_req("R1 clean after reset", 0, 0, 0);

      // R4, R12: external with enable
      cur_req = "R4";
      ext_line = 1'b1;
      cyc(1);
      expect_req("R12 one edge after", 0, 0, 0);
      cyc(1);
      expect_req("R4 external vector", 1, 16'h0500, 0);
      cyc(3);
      expect_req("R2 held without ack", 1, 16'h0500, 0);
      // R7: external not cleared by delivery
      cur_req = "R7";
      do_ack();
      expect_req("R10 dropped after ack", 0, 0, 0);
      cyc(1);
      expect_req("R7 external redelivered", 1, 16'h0500, 0);
      ext_line = 1'b0;
      do_ack();
      cyc(3);
      expect_req("R8 nothing after line drop", 0, 0, 0);

      // R5: gated by enable, strobe delivers
      cur_req = "R5";
      ext_en = 1'b0;
      ext_line = 1'b1;
      cyc(4);
      expect_req("R5 gated", 0, 0, 0);
      ext_en = 1'b1;
      strobe();
      cyc(1);
      expect_req("R5 strobe delivers", 1, 16'h0500, 0);
      ext_line = 1'b0;
      do_ack();
      cyc(2);

      // R8: undelivered external lost when line drops
      cur_req = "R8";
      ext_en = 1'b0;
      ext_line = 1'b1;
      cyc(2);
      ext_line = 1'b0;
      cyc(2);
      ext_en = 1'b1;
      strobe();
      cyc(3);
      expect_req("R8 dropped line lost", 0, 0, 0);

      // R6, R7: decrementer
      cur_req = "R6";
      dec_underflow = 1'b1;
      cyc(1);
      dec_underflow = 1'b0;
      cyc(1);
      expect_req("R6 decrementer vector", 1, 16'h0900, 0);
      cur_req = "R7";
      do_ack();
      cyc(3);
      expect_req("R7 decrementer cleared", 0, 0, 0);
      cur_req = "R6";
      ext_en = 1'b0;
      dec_underflow = 1'b1;
      cyc(1);
      dec_underflow = 1'b0;
      cyc(3);
      expect_req("R6 decrementer gated", 0, 0, 0);
      ext_en = 1'b1;
      strobe();
      cyc(1);
      expect_req("R6 strobe delivers decrementer", 1, 16'h0900, 0);
      do_ack();
      cyc(2);

      // R9: simultaneous sources
      cur_req = "R9";
      ext_line = 1'b1;
      dec_underflow = 1'b1;
      cyc(1);
      dec_underflow = 1'b0;
      cyc(1);
      expect_req("R9 external first", 1, 16'h0500, 0);
      ext_line = 1'b0;
      do_ack();
      cyc(1);
      expect_req("R9 decrementer next", 1, 16'h0900, 0);
      do_ack();
      cyc(2);

      // R10: event while outstanding
      cur_req = "R10";
      ext_line = 1'b1;
      cyc(2);
      expect_req("R10 external outstanding", 1, 16'h0500, 0);
      dec_underflow = 1'b1;
      cyc(1);
      dec_underflow = 1'b0;
      cyc(2);
      expect_req("R10 still holding external", 1, 16'h0500, 0);
      ext_line = 1'b0;
      do_ack();
      cyc(1);
      expect_req("R10 queued decrementer", 1, 16'h0900, 0);
      do_ack();
      cyc(2);

      // R11, R3: FP condition
      cur_req = "R11";
      ext_en = 1'b0;
      fe_mode = 2'b01;
      fex_sum = 1'b1;
      cyc(4);
      expect_req("R11 no strobe no request", 0, 0, 0);
      cur_req = "R3";
      ext_line = 1'b1;
      strobe();
      cyc(1);
      expect_req("R3 FP ignores enable", 1, 16'h0700, FPX_ST);
      ext_en = 1'b1;
      do_ack();
      cyc(1);
      expect_req("R3 FP outranks external", 1, 16'h0700, FPX_ST);
      fex_sum = 1'b0;
      fe_mode = 2'b10;
      do_ack();
      cyc(1);
      expect_req("R4 external after FP", 1, 16'h0500, 0);
      ext_line = 1'b0;
      fe_mode = 2'b00;
      do_ack();
      cyc(2);

      // R1: reset drops an outstanding request
      cur_req = "R1";
      ext_line = 1'b1;
      cyc(2);
      rst_n = 1'b0;
      ext_line = 1'b0;
      cyc(2);
      expect_req("R1 reset clears request", 0, 0, 0);
      rst_n = 1'b1;
      cyc(3);
      expect_req("R1 idle after reset", 0, 0, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule